// File: doc/BRIEF.md
# Masked Pin Configuration Bank

This block is one bank of 32 general-purpose I/O lines behind a 32-bit register bus. Each line has its own configuration word. The bus does not address these words one by one. Software first loads a line-select mask. A single shared configuration port then reads or writes the lines the mask picks. One write can set up any group of lines at once. A read returns the configuration of one line.

Output levels are changed through two write-only registers. One sets lines high and the other clears them low, so no read-modify-write is needed. A status register reads back the output latches. A second status register returns the pad inputs after a two-flop synchronizer. The block holds only configuration state. It exports every configuration field of every line as a flat vector for the pad ring and for the interrupt logic, both of which lie outside this block.

Top module: `pincfg_bank`

## Requirements
- R1: After reset, the following are all zero: the mask, every output latch, every line's configuration and all exported configuration vectors. Every line is therefore a GPIO input with no optional feature enabled.
- R2: A write to byte offset 0x00 loads the line-select mask. A read of 0x00 returns it. When no read is in progress, `bus_rdata` is zero.
- R3: A write to offset 0x04 updates the configuration of every line whose mask bit is 1. Lines whose mask bit is 0 keep their configuration.
- R4: A read of offset 0x04 returns the configuration of the lowest-numbered line whose mask bit is 1. It returns zero when the mask is empty.
- R5: The configuration word has these fields. Bits [2:0] select the function: 0 is GPIO and 1 to 7 are peripheral functions. Bit 8 sets the direction, with 1 meaning output. Bit 9 enables the pull-up and bit 10 enables the pull-down. Bit 12 enables the input glitch filter and bit 13 selects slow-clock filtering. Bit 14 enables open-drain and bit 15 disables the Schmitt trigger. Bits [26:24] select the event type. All other bits are not stored and read back as zero.
- R6: In a write to offset 0x10, each data bit that is 1 drives that line's output latch high. Bits that are 0 leave their latch unchanged. Nothing else changes a latch, apart from R7 and reset.
- R7: In a write to offset 0x14, each data bit that is 1 drives that line's output latch low. Bits that are 0 leave their latch unchanged.
- R8: A read of offset 0x18 returns the output latches of all lines.
- R9: A read of offset 0x08 returns the pad inputs through two flops. A pad value sampled at one rising edge becomes visible after the next rising edge.
- R10: The following accesses have no effect, and reads from them return zero: offset 0x0C (lock status, always zero), offsets 0x1C to 0x3C, and any address whose bits [1:0] are not zero. Writes to the read-only offsets 0x08 and 0x18 are ignored as well.
- R11: Each exported vector reflects the stored fields of every line. Line i occupies bit i of each one-bit vector and bits [3i+2:3i] of the function and event vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Byte offset within the bank window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current access |
| pad_in | input | 32 | Raw pad inputs |
| pad_out | output | 32 | Output latches |
| cfg_func | output | 96 | Function select, 3 bits per line |
| cfg_dir | output | 32 | Direction, 1 means output |
| cfg_pull_up | output | 32 | Pull-up enable |
| cfg_pull_dn | output | 32 | Pull-down enable |
| cfg_filt_en | output | 32 | Glitch filter enable |
| cfg_filt_slow | output | 32 | Slow-clock filter select |
| cfg_open_drain | output | 32 | Open-drain enable |
| cfg_schmitt_off | output | 32 | Schmitt trigger disable |
| cfg_event | output | 96 | Event type, 3 bits per line |

## Verification
Two things can happen in the same cycle: the synchronizer moves a pad change forward, and software reads the pin status register. The bench provokes this by toggling `pad_in` on the same cycles that it reads offset 0x08, both in directed runs and in a long random run. A reference model keeps a history of the pad values sampled at each edge. The bench judges each read against the value from two edges back, never against the pad value of the current cycle. The same per-cycle comparison covers a second pairing: a mask change followed at once by a configuration read. In that case the read must already follow the new mask.

// File: rtl/pincfg_bank.sv
module pincfg_bank #(
  parameter int LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [5:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [LINES-1:0]   pad_in,
  output logic [LINES-1:0]   pad_out,
  output logic [3*LINES-1:0] cfg_func,
  output logic [LINES-1:0]   cfg_dir,
  output logic [LINES-1:0]   cfg_pull_up,
  output logic [LINES-1:0]   cfg_pull_dn,
  output logic [LINES-1:0]   cfg_filt_en,
  output logic [LINES-1:0]   cfg_filt_slow,
  output logic [LINES-1:0]   cfg_open_drain,
  output logic [LINES-1:0]   cfg_schmitt_off,
  output logic [3*LINES-1:0] cfg_event
);

  localparam logic [31:0] CFG_KEEP = 32'h0700_F707;
  localparam logic [3:0] W_MASK = 4'd0, W_CFG = 4'd1, W_PDS = 4'd2,
                         W_SET = 4'd4, W_CLR = 4'd5, W_ODS = 4'd6;

  logic [LINES-1:0] mask_q, out_q, sync1_q, sync2_q;
  logic [31:0]      cfg_q [LINES];
  logic [31:0]      cfg_rd;

  wire       aligned = (bus_addr[1:0] == 2'b00);
  wire [3:0] widx    = bus_addr[5:2];
  wire       wr      = bus_sel & bus_we & aligned;
  wire       rd      = bus_sel & ~bus_we & aligned;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      out_q   <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      if (wr && widx == W_MASK) mask_q <= bus_wdata[LINES-1:0];
      if (wr && widx == W_SET)  out_q  <= out_q | bus_wdata[LINES-1:0];
      if (wr && widx == W_CLR)  out_q  <= out_q & ~bus_wdata[LINES-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) cfg_q[i] <= '0;
    end else if (wr && widx == W_CFG) begin
      for (int i = 0; i < LINES; i++)
        if (mask_q[i]) cfg_q[i] <= bus_wdata & CFG_KEEP;
    end
  end

  always_comb begin
    cfg_rd = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (mask_q[i]) cfg_rd = cfg_q[i];
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (widx)
        W_MASK:  bus_rdata = 32'(mask_q);
        W_CFG:   bus_rdata = cfg_rd;
        W_PDS:   bus_rdata = 32'(sync2_q);
        W_ODS:   bus_rdata = 32'(out_q);
        default: bus_rdata = '0;
      endcase
    end
  end

  assign pad_out = out_q;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign cfg_func[3*g +: 3]  = cfg_q[g][2:0];
    assign cfg_dir[g]          = cfg_q[g][8];
    assign cfg_pull_up[g]      = cfg_q[g][9];
    assign cfg_pull_dn[g]      = cfg_q[g][10];
    assign cfg_filt_en[g]      = cfg_q[g][12];
    assign cfg_filt_slow[g]    = cfg_q[g][13];
    assign cfg_open_drain[g]   = cfg_q[g][14];
    assign cfg_schmitt_off[g]  = cfg_q[g][15];
    assign cfg_event[3*g +: 3] = cfg_q[g][26:24];
  end

endmodule

// File: rtl/pincfg_bank_chk.sv
module pincfg_bank_chk #(
  parameter int LINES = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [5:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic [LINES-1:0] pad_in,
  input logic [LINES-1:0] pad_out,
  input logic [LINES-1:0] cfg_dir,
  input logic [LINES-1:0] mask
);

  logic [1:0] up_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;

  wire set_wr = bus_sel && bus_we && bus_addr == 6'h10;
  wire clr_wr = bus_sel && bus_we && bus_addr == 6'h14;
  wire cfg_wr = bus_sel && bus_we && bus_addr == 6'h04;
  wire pds_rd = bus_sel && !bus_we && bus_addr == 6'h08;

  p_set_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((pad_out & $past(bus_wdata[LINES-1:0])) == $past(bus_wdata[LINES-1:0])));

  p_clear_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((pad_out & $past(bus_wdata[LINES-1:0])) == '0));

  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_wr || clr_wr) |=> $stable(pad_out));

  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_dir));

  p_unmasked_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (((cfg_dir ^ $past(cfg_dir)) & ~$past(mask)) == '0));

  p_sync_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pds_rd && up_cnt >= 2'd2) |-> (bus_rdata[LINES-1:0] == $past(pad_in, 2)));

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_we) |-> (bus_rdata == '0));

endmodule

bind pincfg_bank pincfg_bank_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pad_in(pad_in), .pad_out(pad_out), .cfg_dir(cfg_dir), .mask(mask_q)
);

// File: tb/test_pincfg_bank.sv
module test_pincfg_bank;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pad_in = '0, pad_out;
  logic [3*N-1:0] cfg_func, cfg_event;
  logic [N-1:0] cfg_dir, cfg_pull_up, cfg_pull_dn, cfg_filt_en, cfg_filt_slow;
  logic [N-1:0] cfg_open_drain, cfg_schmitt_off;

  always #10 clk = ~clk;

  pincfg_bank #(.LINES(N)) i_pincfg_bank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .cfg_func(cfg_func), .cfg_dir(cfg_dir),
    .cfg_pull_up(cfg_pull_up), .cfg_pull_dn(cfg_pull_dn), .cfg_filt_en(cfg_filt_en),
    .cfg_filt_slow(cfg_filt_slow), .cfg_open_drain(cfg_open_drain),
    .cfg_schmitt_off(cfg_schmitt_off), .cfg_event(cfg_event)
  );

  int checks = 0, fails = 0;
  logic [31:0] m_mask = '0, m_out = '0;
  logic [31:0] m_cfg [N];
  logic [31:0] padq [$];

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lowest_cfg();
    for (int i = 0; i < N; i++) if (m_mask[i]) return m_cfg[i];
    return 32'h0;
  endfunction

  function automatic logic [31:0] exp_rdata();
    if (!(bus_sel && !bus_we) || bus_addr[1:0] != 2'b00) return 32'h0;
    case (bus_addr)
      6'h00: return m_mask;
      6'h04: return lowest_cfg();
      6'h08: return (padq.size() >= 2) ? padq[0] : 32'h0;
      6'h18: return m_out;
      default: return 32'h0;
    endcase
  endfunction

  task automatic compare_all();
    logic [3*N-1:0] e_func, e_evt;
    logic [N-1:0] e_dir, e_pu, e_pd, e_fe, e_fs, e_od, e_so;
    string tag;
    for (int i = 0; i < N; i++) begin
      e_func[3*i +: 3] = m_cfg[i][2:0];
      e_evt[3*i +: 3]  = m_cfg[i][26:24];
      e_dir[i] = m_cfg[i][8];  e_pu[i] = m_cfg[i][9];  e_pd[i] = m_cfg[i][10];
      e_fe[i]  = m_cfg[i][12]; e_fs[i] = m_cfg[i][13]; e_od[i] = m_cfg[i][14];
      e_so[i]  = m_cfg[i][15];
    end
    if (!(bus_sel && !bus_we)) tag = "R2 idle";
    else if (bus_addr == 6'h00) tag = "R2 mask";
    else if (bus_addr == 6'h04) tag = "R4 cfg read";
    else if (bus_addr == 6'h08) tag = "R9 pin status";
    else if (bus_addr == 6'h18) tag = "R8 out status";
    else tag = "R10 undefined";
    chk(tag, 128'(bus_rdata), 128'(exp_rdata()));
    chk("R6 R7 latches", 128'(pad_out), 128'(m_out));
    chk("R5 func", 128'(cfg_func), 128'(e_func));
    chk("R5 event", 128'(cfg_event), 128'(e_evt));
    chk("R11 dir", 128'(cfg_dir), 128'(e_dir));
    chk("R11 pull", 128'({cfg_pull_up, cfg_pull_dn}), 128'({e_pu, e_pd}));
    chk("R11 filter", 128'({cfg_filt_en, cfg_filt_slow}), 128'({e_fe, e_fs}));
    chk("R11 od schmitt", 128'({cfg_open_drain, cfg_schmitt_off}), 128'({e_od, e_so}));
  endtask

  task automatic cycle(input logic sel, input logic we, input logic [5:0] addr,
                       input logic [31:0] wd, input logic [31:0] pad);
    @(negedge clk);
    bus_sel = sel; bus_we = we; bus_addr = addr; bus_wdata = wd; pad_in = pad;
    #5;
    compare_all();
    @(posedge clk);
    #1;
    if (sel && we && addr[1:0] == 2'b00) begin
      case (addr)
        6'h00: m_mask = wd;
        6'h04: for (int i = 0; i < N; i++) if (m_mask[i]) m_cfg[i] = wd & 32'h0700_F707;
        6'h10: m_out = m_out | wd;
        6'h14: m_out = m_out & ~wd;
        default: ;
      endcase
    end
    padq.push_back(pad);
    if (padq.size() > 2) void'(padq.pop_front());
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    cycle(1'b1, 1'b1, a, d, pad_in);
  endtask
  task automatic rdc(input logic [5:0] a);
    cycle(1'b1, 1'b0, a, 32'h0, pad_in);
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) m_cfg[i] = '0;
    pad_in = 32'hA5A5_5A5A;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk("R1 latches", 128'(pad_out), 128'h0);
    chk("R1 exports", 128'({cfg_func, cfg_event}), 128'h0);
    chk("R1 flags", 128'({cfg_dir, cfg_pull_up, cfg_pull_dn, cfg_filt_en}), 128'h0);
    chk("R1 flags2", 128'({cfg_filt_slow, cfg_open_drain, cfg_schmitt_off}), 128'h0);
    @(negedge clk);
    rst_n = 1'b1;
    padq.delete();
    rdc(6'h00); rdc(6'h04); rdc(6'h18);
    // R3 R5: all bits to line 0, only defined bits stored
    wr(6'h00, 32'h0000_0001); wr(6'h04, 32'hFFFF_FFFF); rdc(6'h04);
    // R3 R4: group write, lowest line readback
    wr(6'h00, 32'h0000_00F0); wr(6'h04, 32'h0300_4105); rdc(6'h04);
    wr(6'h00, 32'h0000_0030); rdc(6'h04); wr(6'h04, 32'h0400_3206); rdc(6'h04);
    wr(6'h00, 32'h8000_0000); rdc(6'h04); wr(6'h04, 32'h0200_8307); rdc(6'h04);
    wr(6'h00, 32'h0); rdc(6'h04); wr(6'h04, 32'hFFFF_FFFF); rdc(6'h04);
    // R6 R7 R8
    wr(6'h10, 32'h0000_FFFF); rdc(6'h18); wr(6'h10, 32'h00F0_0000); rdc(6'h18);
    wr(6'h14, 32'h0000_0F0F); rdc(6'h18); wr(6'h14, 32'h0); rdc(6'h18);
    wr(6'h10, 32'h0); wr(6'h14, 32'hFFFF_FFFF); rdc(6'h18);
    wr(6'h10, 32'h8000_0001); rdc(6'h18);
    // R10: undefined, read-only and unaligned accesses
    wr(6'h0C, 32'hFFFF_FFFF); wr(6'h1C, 32'hFFFF_FFFF); wr(6'h3C, 32'hFFFF_FFFF);
    wr(6'h08, 32'hFFFF_FFFF); wr(6'h18, 32'hFFFF_FFFF); wr(6'h11, 32'hFFFF_FFFF);
    wr(6'h01, 32'hFFFF_FFFF); wr(6'h05, 32'hFFFF_FFFF); wr(6'h15, 32'hFFFF_FFFF);
    rdc(6'h0C); rdc(6'h20); rdc(6'h01); rdc(6'h00); rdc(6'h18);
    // R9: pad changes on the same cycles as status reads
    for (int k = 0; k < 12; k++) cycle(1'b1, 1'b0, 6'h08, 32'h0, 32'h1 << k | (k[0] ? 32'hFFFF_0000 : 32'h0));
    // Random mix
    for (int k = 0; k < 4000; k++) begin
      logic [5:0] a;
      logic [31:0] d;
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0: a = 6'h00; 1, 2: a = 6'h04; 3: a = 6'h08; 4: a = 6'h10;
        5: a = 6'h14; 6: a = 6'h18; 7: a = 6'($urandom_range(0, 63));
        default: a = 6'h04;
      endcase
      d = $urandom();
      if (a == 6'h00) d = ($urandom_range(0, 3) == 0) ? 32'h0 : d & $urandom() & $urandom();
      cycle($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1, a, d,
            ($urandom_range(0, 1) == 1) ? $urandom() : pad_in);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule